// File: doc/BRIEF.md
# Detached Single-Bus Block Mover

This block copies a run of words between one peripheral and main memory on its own, so the processor is only needed at the start and at the end. Software fills four small registers through a register port: a peripheral address, a first memory address, a word count, and a control word. The control word sets the direction of the copy and starts the job. The engine then works word by word. For each word it raises a bus request and waits for a grant. It then spends two bus cycles on the word: a read that loads an internal holding register, and a write that drives the held value out to the other side.

The engine shares a single bus with the processor and has no direct path to the peripheral. Every word therefore crosses the bus twice, and the processor loses the bus for two data cycles per word. Between words the request is dropped for one cycle so that other masters can win the bus. When the last word has been written, the engine sets a done flag and raises its interrupt. Software reads the status word, and that read clears both.

Top module: `dma_detached`

## Requirements
- R1: Register offsets are 0 = peripheral address, 1 = memory address, 2 = word count, 3 = control on write and status on read. Offsets 0 to 2 read back their current value, zero-extended. After reset all four read zero, and `irq`, `bus_req` and `bus_valid` are low.
- R2: A write to offset 3 with bit 1 set starts a job when the engine is idle. In the same write, bit 0 gives the direction: 0 moves words from the peripheral to memory, 1 moves words from memory to the peripheral. While the job runs, status bit 0 (busy) is 1 and status bit 2 shows the direction.
- R3: Each word takes exactly two bus data cycles, back to back: a read (`bus_we`=0) and then a write (`bus_we`=1). The write drives the exact word that the bus returned in the read cycle. A job of N words produces 2N data cycles.
- R4: With direction 0, the read goes to the peripheral (`bus_io`=1, `bus_addr` = peripheral address) and the write goes to memory (`bus_io`=0). With direction 1 the order is reversed. The memory side uses the current memory address. The peripheral address stays fixed for the whole job.
- R5: A word's first data cycle comes only after a cycle in which both `bus_req` and `bus_gnt` were high. `bus_req` goes low in the cycle after each word's write cycle, so it falls exactly N times in an N-word job.
- R6: After each word, the memory address goes up by one and the count goes down by one. When the job ends, offset 1 reads start+N and offset 2 reads 0.
- R7: The job ends when the count steps from 1 to 0. In that same clock edge busy clears, status bit 1 (done) sets, and `irq` rises.
- R8: A start with a count of zero sets done and `irq` at the next edge, with no bus request and no data cycle.
- R9: A read strobe at offset 3 returns the status with done still visible, then clears done and `irq` at that edge.
- R10: While busy, writes to any offset are ignored. This covers a new start, and it covers changes to the peripheral address, memory address and count.
- R11: While idle, `bus_req` and `bus_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; at offset 3 it clears done |
| reg_ofs | input | 2 | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from offset |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Data cycle active |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_io | output | 1 | 1 = peripheral space, 0 = memory space |
| bus_addr | output | AW | Cycle address |
| bus_wdata | output | DW | Write data (holding register) |
| bus_rdata | input | DW | Read data, sampled at the end of a read cycle |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong sequencer state shows up on the bus within one cycle. Examples are a data cycle without a prior grant, a read that is not followed by a write, the same side used twice in one word, or a request held between words. A corrupt holding register shows up in the very next write cycle, as `bus_wdata` differing from the word read one cycle earlier. A fault in the address or count counters shows up as a wrong memory address in a later word or as the wrong number of data cycles. It is also visible in the register readback once the job ends, and in done and `irq` arriving early, late or never.

// File: rtl/dma_detached_pkg.sv
package dma_detached_pkg;
   typedef enum logic [2:0] {
      XS_IDLE,
      XS_REQ,
      XS_RD,
      XS_WR,
      XS_REL
   } xs_t;

   localparam logic [1:0] OFS_DEV = 2'd0;
   localparam logic [1:0] OFS_MEM = 2'd1;
   localparam logic [1:0] OFS_CNT = 2'd2;
   localparam logic [1:0] OFS_CTL = 2'd3;

   localparam int B_DIR  = 0;
   localparam int B_GO   = 1;
   localparam int S_BUSY = 0;
   localparam int S_DONE = 1;
   localparam int S_DIR  = 2;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
   import dma_detached_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_ofs,
   input  logic [DW-1:0] wr_data,
   input  logic          busy,
   input  logic          step,
   output logic [AW-1:0] dev_addr,
   output logic [AW-1:0] mem_addr,
   output logic [CW-1:0] count,
   output logic          dir,
   output logic          go
);
   logic accept;

   // setup is frozen while a job runs
   assign accept = wr_en && !busy;
   assign go     = accept && (wr_ofs == OFS_CTL) && wr_data[B_GO];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev_addr <= '0;
         mem_addr <= '0;
         count    <= '0;
         dir      <= 1'b0;
      end else if (accept) begin
         case (wr_ofs)
            OFS_DEV: dev_addr <= wr_data[AW-1:0];
            OFS_MEM: mem_addr <= wr_data[AW-1:0];
            OFS_CNT: count    <= wr_data[CW-1:0];
            default: dir      <= wr_data[B_DIR];
         endcase
      end else if (step) begin
         mem_addr <= mem_addr + AW'(1);
         count    <= count - CW'(1);
      end
   end
endmodule

// File: rtl/dma_word_seq.sv
module dma_word_seq
   import dma_detached_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic cnt_zero,
   input  logic cnt_last,
   input  logic gnt,
   output xs_t  state,
   output logic busy,
   output logic step,
   output logic last_done
);
   xs_t nxt;

   always_comb begin
      nxt = state;
      case (state)
         XS_IDLE: if (go && !cnt_zero) nxt = XS_REQ;
         XS_REQ:  if (gnt) nxt = XS_RD;
         XS_RD:   nxt = XS_WR;
         XS_WR:   nxt = cnt_last ? XS_IDLE : XS_REL;
         XS_REL:  nxt = XS_REQ;
         default: nxt = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= XS_IDLE;
      else        state <= nxt;
   end

   assign busy      = (state != XS_IDLE);
   assign step      = (state == XS_WR);
   assign last_done = step && cnt_last;
endmodule

// File: rtl/dma_bus_drive.sv
module dma_bus_drive
   import dma_detached_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  xs_t           state,
   input  logic          dir,
   input  logic [AW-1:0] dev_addr,
   input  logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] rdata,
   output logic          req,
   output logic          valid,
   output logic          we,
   output logic          io,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] wdata
);
   logic [DW-1:0] hold_q;

   // read side is the peripheral for dir 0, memory for dir 1; write side is the other
   assign valid = (state == XS_RD) || (state == XS_WR);
   assign we    = (state == XS_WR);
   assign req   = (state == XS_REQ) || valid;
   assign io    = we ? dir : !dir;
   assign addr  = io ? dev_addr : mem_addr;
   assign wdata = hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               hold_q <= '0;
      else if (state == XS_RD)  hold_q <= rdata;
   end
endmodule

// File: rtl/dma_detached.sv
module dma_detached
   import dma_detached_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int CW        = 8,
   parameter bit IRQ_PULSE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic          reg_re,
   input  logic [1:0]    reg_ofs,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic          bus_valid,
   output logic          bus_we,
   output logic          bus_io,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   output logic          irq
);
   localparam int STS_W = S_DIR + 1;

   generate
      if (DW < AW)    begin : g_bad_aw  $error("DW must hold an address"); end
      if (DW < CW)    begin : g_bad_cw  $error("DW must hold a count"); end
      if (DW < STS_W) begin : g_bad_sts $error("DW too narrow for status"); end
      if (CW < 1)     begin : g_bad_cnt $error("CW must be positive"); end
   endgenerate

   logic [AW-1:0] dev_addr, mem_addr;
   logic [CW-1:0] count;
   logic          dir, go, busy, step, last_done, done;
   logic          cnt_zero, cnt_last, done_set, done_clr;
   xs_t           state;

   assign cnt_zero = (count == '0);
   assign cnt_last = (count == CW'(1));

   dma_cfg_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_ofs(reg_ofs),
      .wr_data(reg_wdata), .busy(busy), .step(step),
      .dev_addr(dev_addr), .mem_addr(mem_addr), .count(count),
      .dir(dir), .go(go)
   );

   dma_word_seq u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero),
      .cnt_last(cnt_last), .gnt(bus_gnt), .state(state), .busy(busy),
      .step(step), .last_done(last_done)
   );

   dma_bus_drive #(.AW(AW), .DW(DW)) u_bus (
      .clk(clk), .rst_n(rst_n), .state(state), .dir(dir),
      .dev_addr(dev_addr), .mem_addr(mem_addr), .rdata(bus_rdata),
      .req(bus_req), .valid(bus_valid), .we(bus_we), .io(bus_io),
      .addr(bus_addr), .wdata(bus_wdata)
   );

   assign done_set = last_done || (go && cnt_zero);
   assign done_clr = reg_re && (reg_ofs == OFS_CTL);

   always_ff @(posedge clk) begin
      if (!rst_n)                 done <= 1'b0;
      else if (done_set)          done <= 1'b1;
      else if (go || done_clr)    done <= 1'b0;
   end

   generate
      if (IRQ_PULSE) begin : g_irq_pulse
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= done_set;
         end
         assign irq = irq_q;
      end else begin : g_irq_level
         assign irq = done;
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      case (reg_ofs)
         OFS_DEV: reg_rdata = DW'(dev_addr);
         OFS_MEM: reg_rdata = DW'(mem_addr);
         OFS_CNT: reg_rdata = DW'(count);
         default: begin
            reg_rdata[S_BUSY] = busy;
            reg_rdata[S_DONE] = done;
            reg_rdata[S_DIR]  = dir;
         end
      endcase
   end
endmodule

// File: rtl/dma_detached_chk.sv
module dma_detached_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req,
   input logic          bus_gnt,
   input logic          bus_valid,
   input logic          bus_we,
   input logic          bus_io,
   input logic [DW-1:0] bus_wdata,
   input logic [DW-1:0] bus_rdata,
   input logic          busy,
   input logic          done
);
   AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_we) |-> $past(bus_req && bus_gnt)); // R5
   AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_we) |=> (bus_valid && bus_we)); // R3
   AST_HOLD_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_we) |-> (bus_wdata == $past(bus_rdata))); // R3
   AST_SIDE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_we) |-> (bus_io != $past(bus_io))); // R4
   AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_we) |=> !bus_req); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!bus_req && !bus_valid)); // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R7
endmodule

bind dma_detached dma_detached_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
   .bus_valid(bus_valid), .bus_we(bus_we), .bus_io(bus_io),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done)
);

// File: tb/sim_dma_detached.sv
`timescale 1ns/1ps
module sim_dma_detached;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          reg_we = 1'b0, reg_re = 1'b0;
   logic [1:0]    reg_ofs = 2'd0;
   logic [DW-1:0] reg_wdata = '0;
   wire  [DW-1:0] reg_rdata;
   wire           bus_req, bus_valid, bus_we, bus_io, irq;
   wire  [AW-1:0] bus_addr;
   wire  [DW-1:0] bus_wdata;
   logic          bus_gnt;
   logic [DW-1:0] bus_rdata;

   logic [DW-1:0] mem    [0:255];
   logic [DW-1:0] devlog [0:63];
   int dev_rd_cnt, dev_wr_cnt, gnt_wait;
   int gnt_lat = 0;
   int tests = 0, fails = 0;

   dma_detached #(.AW(AW), .DW(DW), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
      .reg_ofs(reg_ofs), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
      .bus_we(bus_we), .bus_io(bus_io), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // bus-side models: memory, a counting peripheral, an arbiter with latency
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 16'h5000 + 16'(i * 3);
         dev_rd_cnt <= 0;
         dev_wr_cnt <= 0;
         gnt_wait   <= 0;
      end else begin
         gnt_wait <= bus_req ? gnt_wait + 1 : 0;
         if (bus_valid && bus_we) begin
            if (bus_io) begin
               devlog[dev_wr_cnt[5:0]] <= bus_wdata;
               dev_wr_cnt <= dev_wr_cnt + 1;
            end else begin
               mem[bus_addr[7:0]] <= bus_wdata;
            end
         end
         if (bus_valid && !bus_we && bus_io) dev_rd_cnt <= dev_rd_cnt + 1;
      end
   end

   always_comb bus_gnt   = bus_req && (gnt_wait >= gnt_lat);
   always_comb bus_rdata = bus_io ? (16'hA000 + 16'(dev_rd_cnt)) : mem[bus_addr[7:0]];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] ofs, input logic [DW-1:0] val);
      @(negedge clk);
      reg_we = 1'b1; reg_ofs = ofs; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_peek(input logic [1:0] ofs, output logic [DW-1:0] val);
      @(negedge clk);
      reg_ofs = ofs;
      #1 val = reg_rdata;
   endtask

   task automatic run_job(input bit dir, input int n, input logic [15:0] m0,
                          input logic [15:0] dev, input int lat, input bit poke);
      int rd0, wr0, vcnt, bad_ord, bad_dat, bad_gnt, falls, k;
      bit seen, prev_req, prev_gnt, exp_io;
      logic [DW-1:0] held, v;
      logic [15:0] exp_addr;
      gnt_lat = lat;
      reg_wr(2'd0, dev);
      reg_wr(2'd1, m0);
      reg_wr(2'd2, 16'(n));
      rd0 = dev_rd_cnt; wr0 = dev_wr_cnt;
      vcnt = 0; bad_ord = 0; bad_dat = 0; bad_gnt = 0; falls = 0; k = 0;
      seen = 0; prev_req = 0; prev_gnt = 0; held = '0;
      reg_we = 1'b1; reg_ofs = 2'd3; reg_wdata = {14'd0, 1'b1, dir};
      while (!seen && k < 400) begin
         @(negedge clk);
         if (k == 0) reg_we = 1'b0;
         if (poke) begin
            if (k == 2) begin reg_we = 1'b1; reg_ofs = 2'd0; reg_wdata = 16'h07FF; end
            if (k == 3) begin reg_ofs = 2'd2; reg_wdata = 16'd9; end
            if (k == 4) begin reg_ofs = 2'd3; reg_wdata = {14'd0, 1'b1, !dir}; end
            if (k == 5) reg_we = 1'b0;
         end
         if (bus_valid) begin
            exp_io   = (vcnt % 2 == 0) ? !dir : dir;
            exp_addr = exp_io ? dev : m0 + 16'(vcnt / 2);
            if (bus_io != exp_io || bus_we != (vcnt % 2 == 1) || bus_addr != exp_addr) bad_ord++;
            if (vcnt % 2 == 0) begin
               held = bus_rdata;
               if (!prev_gnt) bad_gnt++;
            end else if (bus_wdata != held) bad_dat++;
            vcnt++;
         end
         if (prev_req && !bus_req) falls++;
         prev_req = bus_req; prev_gnt = bus_gnt;
         if (irq) seen = 1;
         if (k == 1 && n > 0 && !poke) begin
            reg_ofs = 2'd3;
            #1 chk(reg_rdata[0] && reg_rdata[2] == dir, "R2 busy/dir while running",
                   32'(reg_rdata), 32'({dir, 2'b01}));
         end
         k++;
      end
      chk(seen, "R7 irq raised at end", 32'(seen), 32'd1);
      if (n == 0) chk(k == 1, "R8 zero count completes next edge", 32'(k), 32'd1);
      chk(vcnt == 2 * n, "R3 two data cycles per word", 32'(vcnt), 32'(2 * n));
      chk(bad_ord == 0, "R4 cycle side/order/address", 32'(bad_ord), 32'd0);
      chk(bad_dat == 0, "R3 write carries read word", 32'(bad_dat), 32'd0);
      chk(bad_gnt == 0, "R5 grant before data", 32'(bad_gnt), 32'd0);
      chk(falls == n, "R5 request released per word", 32'(falls), 32'(n));
      chk(!bus_req && !bus_valid, "R11 quiet when idle", 32'({bus_req, bus_valid}), 32'd0);
      // status read at the completion cycle
      reg_ofs = 2'd3; reg_re = 1'b1;
      #1 chk(reg_rdata[1:0] == 2'b10, "R7 done set, busy clear", 32'(reg_rdata[1:0]), 32'd2);
      @(negedge clk);
      reg_re = 1'b0;
      #1 chk(!irq && !reg_rdata[1], "R9 status read clears done/irq", 32'({irq, reg_rdata[1]}), 32'd0);
      reg_peek(2'd1, v);
      chk(v == m0 + 16'(n), "R6 final memory address", 32'(v), 32'(m0 + 16'(n)));
      reg_peek(2'd2, v);
      chk(v == 16'd0, "R6 final count", 32'(v), 32'd0);
      reg_peek(2'd0, v);
      chk(v == dev, poke ? "R10 busy write ignored" : "R1 peripheral address readback", 32'(v), 32'(dev));
      for (int i = 0; i < n; i++) begin
         if (!dir) chk(mem[m0[7:0] + 8'(i)] == 16'hA000 + 16'(rd0 + i), "R4 peripheral to memory data",
                       32'(mem[m0[7:0] + 8'(i)]), 32'(16'hA000 + 16'(rd0 + i)));
         else      chk(devlog[6'(wr0 + i)] == mem[m0[7:0] + 8'(i)], "R4 memory to peripheral data",
                       32'(devlog[6'(wr0 + i)]), 32'(mem[m0[7:0] + 8'(i)]));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [DW-1:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      for (int o = 0; o < 4; o++) begin
         reg_peek(2'(o), v);
         chk(v == '0, "R1 reset register value", 32'(v), 32'd0);
      end
      chk(!irq && !bus_req && !bus_valid, "R1 reset outputs low", 32'({irq, bus_req, bus_valid}), 32'd0);
      reg_wr(2'd0, 16'h0123);
      reg_wr(2'd1, 16'h0456);
      reg_wr(2'd2, 16'h0007);
      reg_peek(2'd0, v); chk(v == 16'h0123, "R1 offset 0 readback", 32'(v), 32'h123);
      reg_peek(2'd1, v); chk(v == 16'h0456, "R1 offset 1 readback", 32'(v), 32'h456);
      reg_peek(2'd2, v); chk(v == 16'h0007, "R1 offset 2 readback", 32'(v), 32'h7);
      for (int d = 0; d < 2; d++) begin
         for (int n = 0; n < 6; n++) begin
            run_job(d[0], n, 16'(16 + d * 64 + n * 8), 16'(16'h0300 + n), n % 3, 1'b0);
         end
      end
      run_job(1'b0, 4, 16'h00C0, 16'h0321, 1, 1'b1);
      run_job(1'b1, 3, 16'h00D0, 16'h0322, 0, 1'b1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule